// File: doc/BRIEF.md
# Owner Pointer Prediction Cache

This block sits beside a core's private cache and predicts which tile currently owns a memory block. When the private cache misses, the miss address goes into the lookup port while the miss is still being detected. Two cycles later the block returns a destination tile. On a hit that is the predicted owner, so the coherence request goes straight to it. On a miss it is the block's home L2 slice, which forwards the request. A wrong guess costs only a forward, so the table holds hints and never authoritative state.

The table is set-associative. Each entry holds a valid bit, an address tag and an owner identifier wide enough for every tile. It learns in two ways:
- When the local copy of a block is invalidated, the entry is written with the tile that caused the invalidation. This needs no extra messages.
- When the parameter `USE_HINTS` is set, an ownership-change hint names the new owner of a block directly.

A write to a block already in the table replaces that entry. A write to a new block allocates a way. Free ways are used first, and after that tree pseudo-LRU chooses the victim.

Top module: `opc_owner_predictor`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so the first lookup of any address misses.
- R2: A lookup presented in cycle k produces exactly one response, with `rsp_valid` high in cycle k+2. Lookups may be presented on every cycle. No response appears without a lookup.
- R3: On a lookup hit, `rsp_hit` is 1 and `rsp_dest` is the owner identifier stored for that block.
- R4: On a lookup miss, `rsp_hit` is 0 and `rsp_dest` is the home slice, defined as block address bits [OWN_W-1:0].
- R5: An invalidation update stores `inv_requester` as the owner of `inv_addr`.
- R6: A hint update stores `hint_owner` as the owner of `hint_addr`.
- R7: An update to an address that is already resident overwrites its entry in place. A block never occupies two ways.
- R8: The set index is block address bits [SET_W-1:0] and the tag is the remaining upper bits. A new block goes to the lowest-numbered invalid way of its set. If the set has no invalid way, the new block goes to the tree pseudo-LRU victim. Every write, whether it allocates or overwrites, marks its way most recently used. Lookups leave the replacement state unchanged.
- R9: An update and a lookup to the same address in the same cycle: the lookup sees the updated owner. An update presented one cycle after a lookup is not seen by that lookup.
- R10: When an invalidation update and a hint arrive in the same cycle, only the hint is applied and the invalidation update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Block address to look up |
| inv_valid | input | 1 | Local copy invalidated; train the entry |
| inv_addr | input | ADDR_W | Block address of the invalidated copy |
| inv_requester | input | OWN_W | Tile whose request caused the invalidation |
| hint_valid | input | 1 | Ownership-change hint received |
| hint_addr | input | ADDR_W | Block address named by the hint |
| hint_owner | input | OWN_W | New owner tile named by the hint |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | The table held a pointer for the address |
| rsp_dest | output | OWN_W | Tile to send the miss request to |

## Verification
Each lookup result is due two rising edges after the lookup is presented. Every table update is visible to a lookup sampled at the same edge or at any later edge. The bench drives inputs on the falling edge and keeps a behavioural model of the table and replacement state. The model applies each edge's update before it evaluates that edge's lookup, delays the result through a two-entry pipeline, and compares it with the outputs on the falling edge after the second rising edge. Directed sequences use the same timing. They cover the same-cycle and one-cycle-late update cases, the collision between a hint and an invalidation update, and the eviction order in one full set.

// File: rtl/opc_pkg.sv
package opc_pkg;

    // Source of the single table write performed in a cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INV  = 2'd1,
        SRC_HINT = 2'd2
    } upd_src_e;

endpackage

// File: rtl/opc_upd_arb.sv
module opc_upd_arb
    import opc_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int OWN_W     = 4,
    parameter int USE_HINTS = 1
) (
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [OWN_W-1:0]  inv_req,
    input  logic              hint_valid,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic [OWN_W-1:0]  hint_owner,
    output upd_src_e          upd_src,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [OWN_W-1:0]  upd_owner
);

    generate
        if (USE_HINTS != 0) begin : g_hints
            // A hint carries fresher ownership news than a local invalidation
            always_comb begin
                upd_src   = SRC_NONE;
                upd_addr  = inv_addr;
                upd_owner = inv_req;
                if (hint_valid) begin
                    upd_src   = SRC_HINT;
                    upd_addr  = hint_addr;
                    upd_owner = hint_owner;
                end else if (inv_valid) begin
                    upd_src = SRC_INV;
                end
            end
        end else begin : g_base
            logic unused_hint;
            assign unused_hint = ^{hint_valid, hint_addr, hint_owner};
            always_comb begin
                upd_src   = inv_valid ? SRC_INV : SRC_NONE;
                upd_addr  = inv_addr;
                upd_owner = inv_req;
            end
        end
    endgenerate

endmodule

// File: rtl/opc_way_match.sv
module opc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int OWN_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][OWN_W-1:0]  owns,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [WAY_W-1:0]            way,
    output logic [OWN_W-1:0]            owner
);

    logic [WAYS-1:0] eq;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign eq[g] = vld[g] && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        hit   = |eq;
        way   = '0;
        owner = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w]) begin
                way   = WAY_W'(w);
                owner = owns[w];
            end
        end
    end

    // A block is resident in at most one way of its set
    assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq));

endmodule

// File: rtl/opc_plru.sv
module opc_plru #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim
);

    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] bits_q [SETS];
    logic [NODES-1:0] bits_d [SETS];

    // Node n (1-based heap order) lives at bit n-1; 0 steers left
    function automatic logic [WAY_W-1:0] walk(input logic [NODES-1:0] b);
        logic [WAY_W:0] node;
        node = (WAY_W+1)'(1);
        for (int l = 0; l < WAY_W; l++) begin
            node = {node[WAY_W-1:0], b[int'(node) - 1]};
        end
        return node[WAY_W-1:0];
    endfunction

    function automatic logic [NODES-1:0] mark(input logic [NODES-1:0] b,
                                             input logic [WAY_W-1:0] w);
        logic [WAY_W:0]   node;
        logic [NODES-1:0] r;
        r    = b;
        node = {1'b1, w};
        for (int l = 0; l < WAY_W; l++) begin
            r[int'(node >> 1) - 1] = ~node[0];
            node = {1'b0, node[WAY_W:1]};
        end
        return r;
    endfunction

    always_comb begin
        bits_d = bits_q;
        if (touch_en) begin
            bits_d[touch_set] = mark(bits_q[touch_set], touch_way);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                bits_q[s] <= '0;
            end
        end else begin
            bits_q <= bits_d;
        end
    end

    assign victim = walk(bits_q[qry_set]);

    // Checker state: the way just written must not be the next victim
    logic             last_en_q;
    logic [SET_W-1:0] last_set_q;
    logic [WAY_W-1:0] last_way_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_en_q  <= 1'b0;
            last_set_q <= '0;
            last_way_q <= '0;
        end else begin
            last_en_q  <= touch_en;
            last_set_q <= touch_set;
            last_way_q <= touch_way;
        end
    end

    assert_fresh_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_en_q |-> (walk(bits_q[last_set_q]) != last_way_q));

endmodule

// File: rtl/opc_owner_predictor.sv
module opc_owner_predictor
    import opc_pkg::*;
#(
    parameter int  ADDR_W    = 26,
    parameter int  NUM_TILES = 16,
    parameter int  SETS      = 64,
    parameter int  WAYS      = 4,
    parameter int  USE_HINTS = 1,
    localparam int OWN_W     = $clog2(NUM_TILES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [OWN_W-1:0]  inv_requester,
    input  logic              hint_valid,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic [OWN_W-1:0]  hint_owner,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [OWN_W-1:0]  rsp_dest
);

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              lk_v;
        logic [ADDR_W-1:0] lk_a;
        logic              rsp_v;
        logic              rsp_h;
        logic [OWN_W-1:0]  rsp_d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  vld_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];
    logic [OWN_W-1:0] own_q [SETS][WAYS];
    logic [OWN_W-1:0] own_d [SETS][WAYS];

    // ---------------- update selection ----------------
    upd_src_e          upd_src;
    logic [ADDR_W-1:0] upd_addr;
    logic [OWN_W-1:0]  upd_owner;
    logic              upd_valid;

    opc_upd_arb #(
        .ADDR_W(ADDR_W), .OWN_W(OWN_W), .USE_HINTS(USE_HINTS)
    ) u_arb (
        .inv_valid (inv_valid),
        .inv_addr  (inv_addr),
        .inv_req   (inv_requester),
        .hint_valid(hint_valid),
        .hint_addr (hint_addr),
        .hint_owner(hint_owner),
        .upd_src   (upd_src),
        .upd_addr  (upd_addr),
        .upd_owner (upd_owner)
    );

    assign upd_valid = (upd_src != SRC_NONE);

    logic [SET_W-1:0] upd_set;
    logic [TAG_W-1:0] upd_tag;
    assign upd_set = upd_addr[SET_W-1:0];
    assign upd_tag = upd_addr[ADDR_W-1:SET_W];

    logic [WAYS-1:0][TAG_W-1:0] u_tags;
    logic [WAYS-1:0][OWN_W-1:0] u_owns;
    logic                       u_hit;
    logic [WAY_W-1:0]           u_way;
    logic [OWN_W-1:0]           u_own_unused;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            u_tags[w] = tag_q[upd_set][w];
            u_owns[w] = own_q[upd_set][w];
        end
    end

    opc_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .OWN_W(OWN_W)
    ) u_upd_match (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (vld_q[upd_set]),
        .tags (u_tags),
        .owns (u_owns),
        .key  (upd_tag),
        .hit  (u_hit),
        .way  (u_way),
        .owner(u_own_unused)
    );

    // ---------------- victim choice ----------------
    logic             free_any;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] plru_way;
    logic [WAY_W-1:0] wr_way;

    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[upd_set][w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    assign wr_way = u_hit ? u_way : (free_any ? free_way : plru_way);

    opc_plru #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_en (upd_valid),
        .touch_set(upd_set),
        .touch_way(wr_way),
        .qry_set  (upd_set),
        .victim   (plru_way)
    );

    // ---------------- table next state ----------------
    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        own_d = own_q;
        if (upd_valid) begin
            vld_d[upd_set][wr_way] = 1'b1;
            tag_d[upd_set][wr_way] = upd_tag;
            own_d[upd_set][wr_way] = upd_owner;
        end
    end

    // ---------------- lookup second stage ----------------
    logic [SET_W-1:0]           l_set;
    logic [TAG_W-1:0]           l_tag;
    logic [WAYS-1:0][TAG_W-1:0] l_tags;
    logic [WAYS-1:0][OWN_W-1:0] l_owns;
    logic                       l_hit;
    logic [WAY_W-1:0]           l_way_unused;
    logic [OWN_W-1:0]           l_own;

    assign l_set = pipe_q.lk_a[SET_W-1:0];
    assign l_tag = pipe_q.lk_a[ADDR_W-1:SET_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            l_tags[w] = tag_q[l_set][w];
            l_owns[w] = own_q[l_set][w];
        end
    end

    opc_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .OWN_W(OWN_W)
    ) u_lk_match (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (vld_q[l_set]),
        .tags (l_tags),
        .owns (l_owns),
        .key  (l_tag),
        .hit  (l_hit),
        .way  (l_way_unused),
        .owner(l_own)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.lk_v  = lk_valid;
        pipe_d.lk_a  = lk_addr;
        pipe_d.rsp_v = pipe_q.lk_v;
        pipe_d.rsp_h = pipe_q.lk_v && l_hit;
        pipe_d.rsp_d = '0;
        if (pipe_q.lk_v) begin
            pipe_d.rsp_d = l_hit ? l_own : pipe_q.lk_a[OWN_W-1:0];
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
            vld_q  <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        own_q <= own_d;
    end

    assign rsp_valid = pipe_q.rsp_v;
    assign rsp_hit   = pipe_q.rsp_h;
    assign rsp_dest  = pipe_q.rsp_d;

    // ---------------- assertions ----------------
    assert_rsp_after_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ##1 rsp_valid);

    assert_no_rsp_without_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ##1 !rsp_valid);

    assert_miss_goes_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_dest == $past(lk_addr[OWN_W-1:0], 2)));

    // Observer of the last write request taken from the ports
    logic              chk_hint_q;
    logic              chk_inv_q;
    logic [ADDR_W-1:0] chk_addr_q;
    logic [OWN_W-1:0]  chk_own_q;
    logic              probe_hit;
    logic [OWN_W-1:0]  probe_own;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hint_q <= 1'b0;
            chk_inv_q  <= 1'b0;
            chk_addr_q <= '0;
            chk_own_q  <= '0;
        end else begin
            chk_hint_q <= (USE_HINTS != 0) && hint_valid;
            chk_inv_q  <= inv_valid && !((USE_HINTS != 0) && hint_valid);
            chk_addr_q <= ((USE_HINTS != 0) && hint_valid) ? hint_addr : inv_addr;
            chk_own_q  <= ((USE_HINTS != 0) && hint_valid) ? hint_owner : inv_requester;
        end
    end

    always_comb begin
        probe_hit = 1'b0;
        probe_own = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[chk_addr_q[SET_W-1:0]][w] &&
                tag_q[chk_addr_q[SET_W-1:0]][w] == chk_addr_q[ADDR_W-1:SET_W]) begin
                probe_hit = 1'b1;
                probe_own = own_q[chk_addr_q[SET_W-1:0]][w];
            end
        end
    end

    assert_inv_trains_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_inv_q |-> (probe_hit && probe_own == chk_own_q));

    assert_hint_trains_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hint_q |-> (probe_hit && probe_own == chk_own_q));

endmodule

// File: tb/opc_owner_predictor_tb.sv
`timescale 1ns/100ps
module opc_owner_predictor_tb_top;

    localparam int ADDR_W = 26;
    localparam int OWN_W  = 4;
    localparam int SETS   = 64;
    localparam int WAYS   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              inv_valid = 1'b0;
    logic [ADDR_W-1:0] inv_addr = '0;
    logic [OWN_W-1:0]  inv_requester = '0;
    logic              hint_valid = 1'b0;
    logic [ADDR_W-1:0] hint_addr = '0;
    logic [OWN_W-1:0]  hint_owner = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [OWN_W-1:0]  rsp_dest;

    always #2.5 clk = ~clk;

    opc_owner_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_requester(inv_requester),
        .hint_valid(hint_valid), .hint_addr(hint_addr), .hint_owner(hint_owner),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dest(rsp_dest)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_vld [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_own [SETS][WAYS];
    bit m_pl  [SETS][WAYS];   // tree nodes 1..WAYS-1
    bit p1v, p1h, p2v, p2h;
    int p1d, p2d;

    function automatic int m_find(input int a);
        int s = a % SETS;
        int t = a / SETS;
        for (int i = 0; i < WAYS; i++)
            if (m_vld[s][i] && m_tag[s][i] == t) return i;
        return -1;
    endfunction

    task automatic m_write(input int a, input int o);
        int s = a % SETS;
        int w = m_find(a);
        int node;
        if (w < 0)
            for (int i = WAYS - 1; i >= 0; i--) if (!m_vld[s][i]) w = i;
        if (w < 0) begin
            node = 1;
            while (node < WAYS) node = 2 * node + int'(m_pl[s][node]);
            w = node - WAYS;
        end
        m_vld[s][w] = 1'b1;
        m_tag[s][w] = a / SETS;
        m_own[s][w] = o;
        node = w + WAYS;
        while (node > 1) begin
            m_pl[s][node / 2] = (node % 2 == 0);
            node = node / 2;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int i = 0; i < WAYS; i++) begin
                    m_vld[s][i] = 1'b0;
                    m_pl[s][i]  = 1'b0;
                end
            p1v = 0; p2v = 0; p1h = 0; p2h = 0; p1d = 0; p2d = 0;
        end else begin
            int w;
            p2v = p1v; p2h = p1h; p2d = p1d;
            if (hint_valid) m_write(int'(hint_addr), int'(hint_owner));
            else if (inv_valid) m_write(int'(inv_addr), int'(inv_requester));
            p1v = lk_valid;
            p1h = 0;
            p1d = 0;
            if (lk_valid) begin
                w = m_find(int'(lk_addr));
                p1h = (w >= 0);
                p1d = (w >= 0) ? m_own[int'(lk_addr) % SETS][w] : int'(lk_addr) % 16;
            end
        end
    end

    // Compared on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid == p2v, "R2 model rsp_valid", rsp_valid, p2v);
            if (p2v) begin
                chk(rsp_hit == p2h, p2h ? "R3 model hit" : "R4 model hit", rsp_hit, p2h);
                chk(int'(rsp_dest) == p2d, p2h ? "R3 model dest" : "R4 model dest",
                    rsp_dest, p2d);
            end
        end
    end

    // ---------------- stimulus helpers (entered at a falling edge) ----------------
    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
        return ADDR_W'(tag * SETS + set);
    endfunction

    task automatic look(input logic [ADDR_W-1:0] a, input bit eh, input int ed,
                        input string req);
        lk_valid = 1; lk_addr = a;
        @(negedge clk); lk_valid = 0;
        @(negedge clk);
        chk(rsp_valid == 1'b1, req, rsp_valid, 1);
        chk(rsp_hit == eh, req, rsp_hit, eh);
        chk(int'(rsp_dest) == ed, req, rsp_dest, ed);
    endtask

    task automatic upd_inv(input logic [ADDR_W-1:0] a, input int r);
        inv_valid = 1; inv_addr = a; inv_requester = OWN_W'(r);
        @(negedge clk); inv_valid = 0;
    endtask

    task automatic upd_hint(input logic [ADDR_W-1:0] a, input int o);
        hint_valid = 1; hint_addr = a; hint_owner = OWN_W'(o);
        @(negedge clk); hint_valid = 0;
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected < 50000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle after reset", rsp_valid, 0);
        look(mk(4, 6'h23), 0, 3, "R1 first lookup misses");

        // training by invalidation, then by hint (in place)
        upd_inv(mk(4, 6'h23), 5);
        look(mk(4, 6'h23), 1, 5, "R5 invalidation stores requester");
        upd_hint(mk(4, 6'h23), 9);
        look(mk(4, 6'h23), 1, 9, "R6 hint stores new owner");
        look(mk(7, 6'h23), 0, 3, "R4 unrelated tag misses to home");

        // R9: same-cycle update seen
        lk_valid = 1; lk_addr = mk(8, 6'h2A);
        hint_valid = 1; hint_addr = mk(8, 6'h2A); hint_owner = 4'd7;
        @(negedge clk); lk_valid = 0; hint_valid = 0;
        @(negedge clk);
        chk(rsp_hit == 1'b1 && rsp_dest == 4'd7, "R9 same-cycle update seen",
            {rsp_hit, rsp_dest}, {1'b1, 4'd7});

        // R9: update one cycle late not seen
        lk_valid = 1; lk_addr = mk(9, 6'h2B);
        @(negedge clk); lk_valid = 0;
        inv_valid = 1; inv_addr = mk(9, 6'h2B); inv_requester = 4'd2;
        @(negedge clk); inv_valid = 0;
        chk(rsp_hit == 1'b0 && rsp_dest == 4'hB, "R9 late update unseen",
            {rsp_hit, rsp_dest}, {1'b0, 4'hB});
        look(mk(9, 6'h2B), 1, 2, "R9 late update applied afterwards");

        // R10: hint wins a collision
        inv_valid = 1; inv_addr = mk(3, 6'h05); inv_requester = 4'd4;
        hint_valid = 1; hint_addr = mk(3, 6'h05); hint_owner = 4'd2;
        @(negedge clk); inv_valid = 0; hint_valid = 0;
        look(mk(3, 6'h05), 1, 2, "R10 hint wins same address");
        inv_valid = 1; inv_addr = mk(3, 6'h06); inv_requester = 4'd4;
        hint_valid = 1; hint_addr = mk(3, 6'h07); hint_owner = 4'd1;
        @(negedge clk); inv_valid = 0; hint_valid = 0;
        look(mk(3, 6'h06), 0, 6, "R10 colliding invalidation dropped");
        look(mk(3, 6'h07), 1, 1, "R10 colliding hint kept");

        // R7: rewrite in a partly filled set takes no second way
        upd_hint(mk(1, 6'h15), 1);
        upd_hint(mk(1, 6'h15), 6);
        upd_hint(mk(2, 6'h15), 2);
        upd_hint(mk(3, 6'h15), 3);
        upd_hint(mk(4, 6'h15), 4);
        look(mk(1, 6'h15), 1, 6, "R7 rewritten entry holds new owner");
        look(mk(2, 6'h15), 1, 2, "R7 second block kept");
        look(mk(4, 6'h15), 1, 4, "R7 fourth block fits");

        // R8: fill ways 0..3, touch way 0 again, insert: way 2 is the victim
        upd_inv(mk(1, 6'h11), 10);
        upd_inv(mk(2, 6'h11), 11);
        upd_inv(mk(3, 6'h11), 12);
        upd_inv(mk(4, 6'h11), 13);
        look(mk(2, 6'h11), 1, 11, "R8 lookup leaves replacement alone");
        upd_hint(mk(1, 6'h11), 14);
        upd_hint(mk(5, 6'h11), 15);
        look(mk(3, 6'h11), 0, 1, "R8 pseudo-LRU victim evicted");
        look(mk(1, 6'h11), 1, 14, "R8 recently written block kept");
        look(mk(4, 6'h11), 1, 13, "R8 other block kept");
        look(mk(5, 6'h11), 1, 15, "R8 new block resident");

        // R2: back-to-back lookups
        for (int i = 0; i < 4; i++) begin
            lk_valid = 1; lk_addr = mk(i + 1, 6'h11);
            @(negedge clk);
        end
        lk_valid = 0;
        repeat (3) @(negedge clk);

        // mixed traffic, compared against the model every clock
        for (int i = 0; i < 800; i++) begin
            int sets[3] = '{6'h11, 6'h15, 6'h30};
            lk_valid   = $urandom_range(0, 1);
            lk_addr    = mk($urandom_range(1, 6), sets[$urandom_range(0, 2)]);
            inv_valid  = ($urandom_range(0, 3) == 0);
            inv_addr   = mk($urandom_range(1, 6), sets[$urandom_range(0, 2)]);
            inv_requester = OWN_W'($urandom_range(0, 15));
            hint_valid = ($urandom_range(0, 3) == 0);
            hint_addr  = mk($urandom_range(1, 6), sets[$urandom_range(0, 2)]);
            hint_owner = OWN_W'($urandom_range(0, 15));
            @(negedge clk);
        end
        lk_valid = 0; inv_valid = 0; hint_valid = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule